// File: doc/BRIEF.md
# Acquisition Correlation Peak Detector

This block sits behind the inverse-transform engine of a satellite acquisition search. It receives correlation vectors as a stream of complex samples. Each sample is tagged with a satellite number, a coarse 1-kHz shift index and a fine sub-kilohertz bin index. One vector holds one correlation value per code phase, so the position of a sample inside its vector is its code phase. A marker flags the last sample of each vector, and a second marker flags the vector that ends the satellite's search.

For every sample the block forms the power as I squared plus Q squared. Over one satellite's whole search space (code phases times fine bins times coarse shifts) it keeps the largest power and where that power occurred, along with a running sum of all powers and a cell count. When the search closes, it compares the peak against a programmable multiple of the mean power. It then issues one result record: the satellite number, an acquired flag, and the code phase, coarse shift and fine bin of the peak.

Top module: `acq_peak_detector`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `out_valid` is low. A partial search that is under way when reset is applied has no influence on the next result.
- R2: Power is computed at full precision as I*I + Q*Q, with `in_i` and `in_q` taken as two's-complement signed values. Negative components give the same power as positive ones.
- R3: Code phase is the zero-based index of a sample within its vector. The index restarts at 0 on the sample after one that carries `in_last`.
- R4: The result reports the code phase, coarse shift and fine bin of the largest power seen in the satellite's search. When powers are equal, the location that arrived first is kept.
- R5: A sample whose `in_sat` differs from the satellite currently being searched discards the running peak, sum and count, and starts a new search with that sample.
- R6: `out_acquired` is 1 exactly when peak * count * 2^THR_FRAC > thr * sum. Here sum and count cover every sample of the search, `thr` is unsigned with THR_FRAC fraction bits, and the comparison is strict, so equality gives 0.
- R7: A sample with `in_valid`, `in_last` and `in_final` all high causes exactly one result: `out_valid` is high for one cycle, two clock edges after that sample is taken, and `out_sat` gives the sample's satellite number.
- R8: After a result has been issued, the next sample starts a new search even if it carries the same satellite number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Correlation sample present |
| in_i | input | 16 | In-phase component, signed |
| in_q | input | 16 | Quadrature component, signed |
| in_sat | input | 5 | Satellite number of the sample |
| in_coarse | input | 4 | Coarse 1-kHz shift index |
| in_fine | input | 2 | Fine bin index (up to four bins per kHz) |
| in_last | input | 1 | Last sample of a vector |
| in_final | input | 1 | Sample belongs to the vector that closes the satellite's search |
| thr | input | THR_W | Detection factor, unsigned, THR_FRAC fraction bits |
| out_valid | output | 1 | Result record present (one cycle) |
| out_sat | output | 5 | Satellite number of the result |
| out_acquired | output | 1 | Threshold test passed |
| out_phase | output | $clog2(N1) | Code phase of the peak |
| out_coarse | output | 4 | Coarse shift of the peak |
| out_fine | output | 2 | Fine bin of the peak |

## Verification
A result record is due two clock edges after the closing sample is taken: one edge registers the power, and the next updates the search and registers the record. The bench drives every sample on a falling edge. After the closing sample it waits exactly one more falling edge and checks that `out_valid` and all result fields are present. It checks again one falling edge later that `out_valid` has dropped, which confirms the single pulse. The expected location and decision in each search come from the bench's own knowledge of where it placed the peak and from the power, sum and count arithmetic stated in the requirements.

// File: rtl/acq_pkg.sv
package acq_pkg;

    localparam int IQ_W     = 16;
    localparam int SAT_W    = 5;
    localparam int COARSE_W = 4;
    localparam int FINE_W   = 2;
    localparam int PWR_W    = 2 * IQ_W + 1;

    typedef struct packed {
        logic [SAT_W-1:0]    sat;
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
        logic                last;
        logic                fin;
    } sample_tag_t;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
    } freq_loc_t;

    function automatic logic [PWR_W-1:0] power_of(
        input logic signed [IQ_W-1:0] i_v,
        input logic signed [IQ_W-1:0] q_v
    );
        logic signed [2*IQ_W-1:0] ii;
        logic signed [2*IQ_W-1:0] qq;
        ii = i_v * i_v;
        qq = q_v * q_v;
        return PWR_W'($unsigned(ii)) + PWR_W'($unsigned(qq));
    endfunction

endpackage

// File: rtl/acq_power_stage.sv
module acq_power_stage
    import acq_pkg::*;
#(
    parameter int N1   = 8,
    parameter int PH_W = $clog2(N1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [IQ_W-1:0] in_i,
    input  logic signed [IQ_W-1:0] in_q,
    input  sample_tag_t            in_tag,
    output logic                   s1_valid,
    output logic [PWR_W-1:0]       s1_power,
    output sample_tag_t            s1_tag,
    output logic [PH_W-1:0]        s1_phase
);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= '0;
            s1_valid <= 1'b0;
            s1_power <= '0;
            s1_tag   <= '0;
            s1_phase <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_power <= power_of(in_i, in_q);
                s1_tag   <= in_tag;
                s1_phase <= phase_q;
                phase_q  <= in_tag.last ? '0 : phase_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/acq_peak_tracker.sv
module acq_peak_tracker
    import acq_pkg::*;
#(
    parameter int PH_W  = 3,
    parameter int CNT_W = 16,
    parameter int SUM_W = PWR_W + CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               s1_valid,
    input  logic [PWR_W-1:0]   s1_power,
    input  sample_tag_t        s1_tag,
    input  logic [PH_W-1:0]    s1_phase,
    output logic               fresh,
    output logic [PWR_W-1:0]   peak_q,
    output logic [CNT_W-1:0]   cnt_q,
    output logic [PWR_W-1:0]   nxt_peak,
    output logic [PH_W-1:0]    nxt_phase,
    output freq_loc_t          nxt_loc,
    output logic [SUM_W-1:0]   nxt_sum,
    output logic [CNT_W-1:0]   nxt_cnt
);

    logic             empty_q;
    logic [SAT_W-1:0] sat_q;
    logic [PH_W-1:0]  phase_q;
    freq_loc_t        loc_q;
    logic [SUM_W-1:0] sum_q;
    freq_loc_t        in_loc;

    assign in_loc = '{coarse: s1_tag.coarse, fine: s1_tag.fine};
    assign fresh  = empty_q || (s1_tag.sat != sat_q);

    always_comb begin
        if (fresh) begin
            nxt_peak  = s1_power;
            nxt_phase = s1_phase;
            nxt_loc   = in_loc;
            nxt_sum   = SUM_W'(s1_power);
            nxt_cnt   = CNT_W'(1);
        end else begin
            if (s1_power > peak_q) begin
                nxt_peak  = s1_power;
                nxt_phase = s1_phase;
                nxt_loc   = in_loc;
            end else begin
                nxt_peak  = peak_q;
                nxt_phase = phase_q;
                nxt_loc   = loc_q;
            end
            nxt_sum = sum_q + SUM_W'(s1_power);
            nxt_cnt = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_q <= 1'b1;
            sat_q   <= '0;
            peak_q  <= '0;
            phase_q <= '0;
            loc_q   <= '0;
            sum_q   <= '0;
            cnt_q   <= '0;
        end else if (s1_valid) begin
            empty_q <= s1_tag.last && s1_tag.fin;
            sat_q   <= s1_tag.sat;
            peak_q  <= nxt_peak;
            phase_q <= nxt_phase;
            loc_q   <= nxt_loc;
            sum_q   <= nxt_sum;
            cnt_q   <= nxt_cnt;
        end
    end

endmodule

// File: rtl/acq_threshold.sv
module acq_threshold
    import acq_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SUM_W    = PWR_W + CNT_W,
    parameter int THR_W    = 8,
    parameter int THR_FRAC = 4,
    parameter int CMP_W    = SUM_W + THR_W + THR_FRAC
) (
    input  logic [PWR_W-1:0] peak,
    input  logic [SUM_W-1:0] sum,
    input  logic [CNT_W-1:0] cnt,
    input  logic [THR_W-1:0] thr,
    output logic             hit
);

    logic [CMP_W-1:0] lhs;
    logic [CMP_W-1:0] rhs;

    always_comb begin
        lhs = (CMP_W'(peak) * CMP_W'(cnt)) << THR_FRAC;
        rhs = CMP_W'(thr) * CMP_W'(sum);
        hit = lhs > rhs;
    end

endmodule

// File: rtl/acq_peak_detector.sv
module acq_peak_detector
    import acq_pkg::*;
#(
    parameter int N1       = 8,
    parameter int CNT_W    = 16,
    parameter int THR_W    = 8,
    parameter int THR_FRAC = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [IQ_W-1:0]     in_i,
    input  logic signed [IQ_W-1:0]     in_q,
    input  logic [SAT_W-1:0]           in_sat,
    input  logic [COARSE_W-1:0]        in_coarse,
    input  logic [FINE_W-1:0]          in_fine,
    input  logic                       in_last,
    input  logic                       in_final,
    input  logic [THR_W-1:0]           thr,
    output logic                       out_valid,
    output logic [SAT_W-1:0]           out_sat,
    output logic                       out_acquired,
    output logic [$clog2(N1)-1:0]      out_phase,
    output logic [COARSE_W-1:0]        out_coarse,
    output logic [FINE_W-1:0]          out_fine
);

    localparam int PH_W  = $clog2(N1);
    localparam int SUM_W = PWR_W + CNT_W;

    sample_tag_t      in_tag;
    logic             s1_valid;
    logic [PWR_W-1:0] s1_power;
    sample_tag_t      s1_tag;
    logic [PH_W-1:0]  s1_phase;
    logic             trk_fresh;
    logic [PWR_W-1:0] trk_peak_q;
    logic [CNT_W-1:0] trk_cnt_q;
    logic [PWR_W-1:0] nxt_peak;
    logic [PH_W-1:0]  nxt_phase;
    freq_loc_t        nxt_loc;
    logic [SUM_W-1:0] nxt_sum;
    logic [CNT_W-1:0] nxt_cnt;
    logic             hit;
    logic             closing;

    assign in_tag = '{sat: in_sat, coarse: in_coarse, fine: in_fine,
                      last: in_last, fin: in_final};

    acq_power_stage #(.N1(N1), .PH_W(PH_W)) u_power (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .in_tag(in_tag), .s1_valid(s1_valid), .s1_power(s1_power),
        .s1_tag(s1_tag), .s1_phase(s1_phase)
    );

    acq_peak_tracker #(.PH_W(PH_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_track (
        .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_power(s1_power),
        .s1_tag(s1_tag), .s1_phase(s1_phase), .fresh(trk_fresh),
        .peak_q(trk_peak_q), .cnt_q(trk_cnt_q), .nxt_peak(nxt_peak),
        .nxt_phase(nxt_phase), .nxt_loc(nxt_loc), .nxt_sum(nxt_sum),
        .nxt_cnt(nxt_cnt)
    );

    acq_threshold #(.CNT_W(CNT_W), .SUM_W(SUM_W), .THR_W(THR_W),
                    .THR_FRAC(THR_FRAC)) u_thr (
        .peak(nxt_peak), .sum(nxt_sum), .cnt(nxt_cnt), .thr(thr), .hit(hit)
    );

    assign closing = s1_valid && s1_tag.last && s1_tag.fin;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_sat      <= '0;
            out_acquired <= 1'b0;
            out_phase    <= '0;
            out_coarse   <= '0;
            out_fine     <= '0;
        end else begin
            out_valid <= closing;
            if (closing) begin
                out_sat      <= s1_tag.sat;
                out_acquired <= hit;
                out_phase    <= nxt_phase;
                out_coarse   <= nxt_loc.coarse;
                out_fine     <= nxt_loc.fine;
            end
        end
    end

endmodule

// File: rtl/acq_peak_checker.sv
module acq_peak_checker
    import acq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_last,
    input logic             in_final,
    input logic             out_valid,
    input logic             s1_valid,
    input logic             trk_fresh,
    input logic [PWR_W-1:0] trk_peak_q,
    input logic [CNT_W-1:0] trk_cnt_q
);

    // R7: a record only follows a closing sample taken two edges earlier
    p_record_has_cause_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && in_last && in_final, 2));

    // R7: a closing sample with no reset in between yields a record
    p_record_due_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid && in_last && in_final, 2) && !$past(rst, 1) && !$past(rst, 2))
        |-> out_valid);

    // R4: within one search the held peak never decreases
    p_peak_nondecreasing_r4: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && !trk_fresh) |=> (trk_peak_q >= $past(trk_peak_q)));

    // R6: every sample of an ongoing search adds one to the cell count
    p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && !trk_fresh) |=> (trk_cnt_q == $past(trk_cnt_q) + CNT_W'(1)));

    // R5: a new search starts its count at one
    p_fresh_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && trk_fresh) |=> (trk_cnt_q == CNT_W'(1)));

endmodule

bind acq_peak_detector acq_peak_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
    .in_final(in_final), .out_valid(out_valid), .s1_valid(s1_valid),
    .trk_fresh(trk_fresh), .trk_peak_q(trk_peak_q), .trk_cnt_q(trk_cnt_q)
);

// File: tb/test_acq_peak_detector.sv
module test_acq_peak_detector;

    localparam int CLK_PERIOD = 10;
    localparam int N1 = 4;
    localparam int NCO = 2;
    localparam int NFI = 2;
    localparam int NSC = 6;

    // scenario table: sat, thr, peak I, peak Q, phase, coarse, fine, expected flag
    localparam int SC_SAT[NSC] = '{1, 2, 3, 7, 8, 24};
    localparam int SC_THR[NSC] = '{64, 64, 64, 160, 159, 64};
    localparam int SC_PI[NSC]  = '{5, 2, 3, 5, -5, 0};
    localparam int SC_PQ[NSC]  = '{0, 0, 4, 0, 0, -4};
    localparam int SC_PH[NSC]  = '{2, 1, 3, 0, 0, 1};
    localparam int SC_CO[NSC]  = '{1, 0, 1, 0, 1, 0};
    localparam int SC_FI[NSC]  = '{0, 1, 1, 1, 0, 0};
    localparam int SC_ACQ[NSC] = '{1, 0, 1, 0, 1, 1};

    logic clk = 1'b0;
    logic rst;
    logic in_valid;
    logic signed [15:0] in_i, in_q;
    logic [4:0] in_sat;
    logic [3:0] in_coarse;
    logic [1:0] in_fine;
    logic in_last, in_final;
    logic [7:0] thr;
    logic out_valid;
    logic [4:0] out_sat;
    logic out_acquired;
    logic [1:0] out_phase;
    logic [3:0] out_coarse;
    logic [1:0] out_fine;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    acq_peak_detector #(.N1(N1)) i_acq_peak_detector (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .in_sat(in_sat), .in_coarse(in_coarse), .in_fine(in_fine),
        .in_last(in_last), .in_final(in_final), .thr(thr),
        .out_valid(out_valid), .out_sat(out_sat), .out_acquired(out_acquired),
        .out_phase(out_phase), .out_coarse(out_coarse), .out_fine(out_fine)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input int i, input int q, input int sat, input int co,
                         input int fi, input bit last, input bit fin);
        in_valid  = 1'b1;
        in_i      = 16'(i);
        in_q      = 16'(q);
        in_sat    = 5'(sat);
        in_coarse = 4'(co);
        in_fine   = 2'(fi);
        in_last   = last;
        in_final  = fin;
        @(negedge clk);
    endtask

    // one search: background I value bg, peak A always, peak B if b_en;
    // full=0 sends only the first vector without the closing marker
    task automatic search(input int sat, input int t, input int pi, input int pq,
                          input int aph, input int aco, input int afi,
                          input bit b_en, input int bph, input int bco, input int bfi,
                          input int bg, input bit full);
        thr = 8'(t);
        for (int co = 0; co < NCO; co++) begin
            for (int fi = 0; fi < NFI; fi++) begin
                for (int ph = 0; ph < N1; ph++) begin
                    bit is_pk;
                    bit lastv;
                    is_pk = (ph == aph && co == aco && fi == afi) ||
                            (b_en && ph == bph && co == bco && fi == bfi);
                    lastv = full && (co == NCO-1) && (fi == NFI-1);
                    if (!full && (co != 0 || fi != 0)) continue;
                    drive(is_pk ? pi : bg, is_pk ? pq : 0, sat, co, fi,
                          ph == N1-1, lastv);
                end
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_final = 1'b0;
    endtask

    task automatic expect_result(input string req, input int sat, input int acq,
                                 input int ph, input int co, input int fi);
        @(negedge clk);
        check({req, " R7 valid"}, int'(out_valid), 1);
        check({req, " R7 sat"}, int'(out_sat), sat);
        check({req, " R6 flag"}, int'(out_acquired), acq);
        check({req, " R3 phase"}, int'(out_phase), ph);
        check({req, " R4 coarse"}, int'(out_coarse), co);
        check({req, " R4 fine"}, int'(out_fine), fi);
        @(negedge clk);
        check({req, " R7 single pulse"}, int'(out_valid), 0);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_i = '0; in_q = '0; in_sat = '0;
        in_coarse = '0; in_fine = '0; in_last = 1'b0; in_final = 1'b0; thr = 8'd64;
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset out_valid", int'(out_valid), 0);

        // table walk: R2 power forms, R3 phases, R6 threshold boundary
        for (int s = 0; s < NSC; s++) begin
            search(SC_SAT[s], SC_THR[s], SC_PI[s], SC_PQ[s], SC_PH[s], SC_CO[s],
                   SC_FI[s], 1'b0, 0, 0, 0, 1, 1'b1);
            expect_result($sformatf("R2 table %0d", s), SC_SAT[s], SC_ACQ[s],
                          SC_PH[s], SC_CO[s], SC_FI[s]);
        end

        // R4: all equal powers, first cell wins; 4*16*16 vs 64*64 -> not acquired
        search(9, 64, 2, 0, 0, 0, 0, 1'b0, 0, 0, 0, 2, 1'b1);
        expect_result("R4 all tie", 9, 0, 0, 0, 0);

        // R4: two equal peaks, earlier (coarse 0 fine 1 phase 3) kept
        search(9, 64, 5, 0, 0, 1, 0, 1'b1, 3, 0, 1, 1, 1'b1);
        expect_result("R4 two peaks", 9, 1, 3, 0, 1);

        // R5: partial search of sat 10 with big peak, then sat 11 full
        search(10, 64, 9, 0, 1, 0, 0, 1'b0, 0, 0, 0, 1, 1'b0);
        @(negedge clk);
        check("R5 no record for partial", int'(out_valid), 0);
        search(11, 64, 4, 0, 2, 1, 1, 1'b0, 0, 0, 0, 1, 1'b1);
        expect_result("R5 tag change", 11, 1, 2, 1, 1);

        // R1: reset during a partial search of sat 12
        search(12, 64, 9, 0, 1, 0, 0, 1'b0, 0, 0, 0, 1, 1'b0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 mid reset out_valid", int'(out_valid), 0);
        rst = 1'b0;
        search(12, 64, 4, 0, 3, 0, 0, 1'b0, 0, 0, 0, 1, 1'b1);
        expect_result("R1 reset clears", 12, 1, 3, 0, 0);

        // R8: same satellite searched twice back to back, smaller peak second
        search(13, 64, 9, 0, 0, 0, 0, 1'b0, 0, 0, 0, 1, 1'b1);
        expect_result("R8 first", 13, 1, 0, 0, 0);
        search(13, 64, 3, 0, 1, 1, 1, 1'b0, 0, 0, 0, 1, 1'b1);
        expect_result("R8 second", 13, 1, 1, 1, 1);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule